// File: doc/BRIEF.md
# Clock Generator Configuration Register Target (I2C)

This block is the two-wire serial target that gives a bus controller access to a small bank of byte-wide configuration and status registers in a clock generator. The target answers to a seven-bit address. The upper four bits of that address are fixed at `1101`. The lower three bits come from strap pins, so up to eight such devices can share one bus.

In a write, the controller sends the device address, a register pointer and one or more data bytes. In a read, the controller first sets the pointer with a write, then issues a repeated START with the read bit, and the target returns bytes MSB first. The pointer advances after every data byte. This lets a single transaction walk through consecutive registers.

The register contents are driven in parallel to the clock-synthesis core. Register 0 is a read-only image of the resolved device address. Register 5 is a read-only window onto a status bus. SCL and SDA are sampled through synchronizers in the system clock domain. SDA is driven only as an open-drain pull-down enable.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `1101` followed by `strap_i[2:0]`. After a mismatching address it leaves SDA released, for that byte and all later bytes, until the next START or STOP.
- R2: A write (START, address with bit 0 = 0, pointer byte, data byte) acknowledges every byte and stores the data byte into the register selected by the pointer.
- R3: After a pointer has been set, a repeated START with address bit 0 = 1 makes the target shift out the selected register MSB first. Each bit is valid while SCL is high.
- R4: Register 0 reads as bit 7 = 0, bits 6..3 = `1101` and bits 2..0 = `strap_i[2:0]`.
- R5: Writes to register 0 and register 5 are acknowledged but change nothing. Register 5 always reads the current `status_i`.
- R6: Pointer values above 7 are acknowledged. Data bytes written there are acknowledged and discarded, and reads there return 0x00.
- R7: The pointer increments by one after each data byte in both directions, so multi-byte writes and reads cover consecutive registers.
- R8: After the controller NACKs a read byte, the target keeps SDA released until a STOP or a repeated START.
- R9: A START or STOP at any point aborts the transaction in progress. A partially received data byte is not stored, and SDA is released in the cycle after the condition is detected.
- R10: While `rst_n` is low, the writable registers (1, 2, 3, 4, 6, 7) clear to 0x00 and SDA is released.
- R11: The target changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| strap_i | input | 3 | Address strap pins, lower three address bits |
| status_i | input | 8 | Status bus presented as register 5 |
| regs_o | output | 64 | Register image, register n at bits 8n+7..8n |

## Verification
The hardest situation to reach from the ports is a STOP that arrives in the middle of a data byte, after the pointer has already been accepted. It only shows whether a half-assembled byte leaks into a register if the stored value differs from that partial pattern. The stimulus sets a pointer, clocks four bits of a byte whose complete value would change the register, and then issues STOP. It then confirms that the register image is unchanged and that a fresh transaction still works.

The other hard corner is a read that continues past the last register. There the pointer must wrap into the empty region and return zero, and the target must let go of the line after the final NACK.

// File: rtl/clkcfg_pkg.sv
// Shared constants and types for the configuration register target.
// Assumes an 8-bit register pointer and 8-bit registers.
package clkcfg_pkg;
    localparam int          BYTE_W     = 8;
    localparam int          STRAP_W    = 3;
    localparam logic [3:0]  DEV_PREFIX = 4'b1101;
    localparam int          ID_IDX     = 0;
    localparam int          STATUS_IDX = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_ADDR,
        ST_ACK_ADDR,
        ST_RX_PTR,
        ST_ACK_PTR,
        ST_RX_DATA,
        ST_ACK_DATA,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } bus_state_e;
endpackage

// File: rtl/clkcfg_line_sync.sv
// Brings SCL and SDA into the clk domain through a flop chain and
// derives edge and bus-condition strobes from the synchronized levels.
// Assumes the bus is idle high after reset.
module clkcfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chains, reset to the idle-high bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge strobes and START/STOP conditions (SDA moving while SCL stays high).
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/clkcfg_i2c_engine.sv
// Protocol engine: address match, pointer load, byte receive and transmit,
// ACK generation and pointer auto-increment. Emits a one-cycle write strobe
// for every received data byte; the register bank decides what is writable.
// Assumes synchronized inputs and no clock stretching.
module clkcfg_i2c_engine
    import clkcfg_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               wr_en,
    output logic [PTR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]  wr_data,
    output logic [PTR_W-1:0]   ptr_o
);
    localparam int CNT_W = $clog2(BYTE_W) + 1;

    bus_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [PTR_W-1:0]  ptr;
    logic              rd_mode;
    logic              byte_done;
    logic              addr_hit;

    // Byte completion and address comparison.
    always_comb begin
        byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
        addr_hit  = (rx_sr[BYTE_W-1:1] == {DEV_PREFIX, strap_i});
    end

    // Main transaction sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            ptr     <= '0;
            rd_mode <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_RX_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX_ADDR, ST_RX_PTR, ST_RX_DATA: begin
                        if (scl_rise && bit_cnt != CNT_W'(BYTE_W)) begin
                            rx_sr   <= {rx_sr[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_RX_ADDR) begin
                                if (addr_hit) begin
                                    rd_mode <= rx_sr[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK_ADDR;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else if (state == ST_RX_PTR) begin
                                ptr    <= rx_sr;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK_PTR;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= rx_sr;
                                ptr     <= ptr + 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK_DATA;
                            end
                        end
                    end
                    ST_ACK_ADDR: begin
                        if (scl_fall) begin
                            if (rd_mode) begin
                                tx_sr   <= rd_data;
                                ptr     <= ptr + 1'b1;
                                sda_oe  <= ~rd_data[BYTE_W-1];
                                bit_cnt <= '0;
                                state   <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX_PTR;
                            end
                        end
                    end
                    ST_ACK_PTR, ST_ACK_DATA: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX_DATA;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~tx_sr[BYTE_W-2];
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise && sda_s) begin
                            state <= ST_WAIT;
                        end else if (scl_fall) begin
                            tx_sr   <= rd_data;
                            ptr     <= ptr + 1'b1;
                            sda_oe  <= ~rd_data[BYTE_W-1];
                            bit_cnt <= '0;
                            state   <= ST_TX;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign ptr_o = ptr;
endmodule

// File: rtl/clkcfg_regbank.sv
// Register bank: fixed identity register, status window and writable bytes.
// Writes to non-writable or out-of-range slots are dropped; reads beyond the
// bank return zero. Assumes NUM_REGS is a power of two no larger than 2**PTR_W.
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int PTR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [PTR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [PTR_W-1:0]           rd_addr,
    input  logic [STRAP_W-1:0]         strap_i,
    input  logic [BYTE_W-1:0]          status_i,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [BYTE_W-1:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        if (g == ID_IDX) begin : g_id
            assign bank[g] = {1'b0, DEV_PREFIX, strap_i};
        end else if (g == STATUS_IDX) begin : g_status
            assign bank[g] = status_i;
        end else begin : g_rw
            logic [BYTE_W-1:0] q;
            // Writable byte, loaded when the strobe targets this slot.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_addr == PTR_W'(g))
                    q <= wr_data;
            end
            assign bank[g] = q;
        end
        assign regs_o[g*BYTE_W +: BYTE_W] = bank[g];
    end

    // Read port with zero fill above the bank.
    always_comb begin
        if (rd_addr < PTR_W'(NUM_REGS))
            rd_data = bank[rd_addr[IDX_W-1:0]];
        else
            rd_data = '0;
    end
endmodule

// File: rtl/clkcfg_i2c_target.sv
// Top level: line synchronizer, protocol engine and register bank.
// Assumes an external open-drain pad driven low while sda_oe is 1.
module clkcfg_i2c_target
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int PTR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    input  logic [STRAP_W-1:0]         strap_i,
    input  logic [BYTE_W-1:0]          status_i,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] rd_data;

    clkcfg_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    clkcfg_i2c_engine #(.PTR_W(PTR_W)) engine_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .strap_i(strap_i), .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ptr_o(ptr)
    );

    clkcfg_regbank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(ptr), .strap_i(strap_i),
        .status_i(status_i), .rd_data(rd_data), .regs_o(regs_o)
    );
endmodule

// File: rtl/clkcfg_i2c_checker.sv
// Protocol and register-protection properties, bound into the top level.
module clkcfg_i2c_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_oe,
    input logic        scl_s,
    input logic        start_det,
    input logic        stop_det,
    input logic        wr_en,
    input logic [7:0]  wr_addr,
    input logic [7:0]  wr_data,
    input logic [2:0]  strap_i,
    input logic [7:0]  status_i,
    input logic [63:0] regs_o
);
    p_sda_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_oe);

    p_id_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'd0) |=> regs_o[7:0] == {1'b0, 4'b1101, strap_i});

    p_status_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'd5) |=> regs_o[47:40] == status_i);

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'd2) |=> regs_o[23:16] == $past(wr_data));

    p_high_ptr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > 8'd7 && $stable(status_i)) |=> $stable(regs_o));
endmodule

bind clkcfg_i2c_target clkcfg_i2c_checker chk_i (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .strap_i(strap_i),
    .status_i(status_i), .regs_o(regs_o)
);

// File: tb/clkcfg_i2c_target_tb.sv
// Bench: behavioural bus controller plus a register-image model compared on
// every clock while no write is in flight.
module clkcfg_i2c_target_tb_top;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_scl = 1'b1;
    logic        tb_sda_low = 1'b0;
    logic [2:0]  strap = 3'b101;
    logic [7:0]  status = 8'h3C;
    logic        sda_oe;
    logic [63:0] regs;
    logic        sda_line;

    assign sda_line = !(tb_sda_low || sda_oe);

    always #10 clk = ~clk;

    clkcfg_i2c_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(tb_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .status_i(status), .regs_o(regs)
    );

    int         vectors = 0;
    int         miscompares = 0;
    bit         settled = 1'b0;
    bit         done = 1'b0;
    logic [7:0] mdl [8];
    int         mptr = 0;

    function automatic logic [7:0] exp_reg(int a);
        if (a == 0) return {1'b0, 4'b1101, strap};
        if (a == 5) return status;
        if (a < 8) return mdl[a];
        return 8'h00;
    endfunction

    function automatic logic [63:0] exp_image();
        logic [63:0] e;
        for (int k = 0; k < 8; k++) e[8*k +: 8] = exp_reg(k);
        return e;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the register image (R2, R5, R10).
    always @(negedge clk) begin
        if (settled && !done) check("R2 register image", regs, exp_image());
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tb_sda_low = 1'b0; wclk(H/2);
        tb_scl = 1'b1;     wclk(H);
        tb_sda_low = 1'b1; wclk(H);
        tb_scl = 1'b0;     wclk(H/2);
    endtask

    task automatic bus_stop();
        tb_sda_low = 1'b1; wclk(H/2);
        tb_scl = 1'b1;     wclk(H);
        tb_sda_low = 1'b0; wclk(H);
    endtask

    task automatic send_bit(input logic b);
        tb_sda_low = !b; wclk(H/2);
        tb_scl = 1'b1;   wclk(H);
        tb_scl = 1'b0;   wclk(H/2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        tb_sda_low = 1'b0; wclk(H/2);
        tb_scl = 1'b1;     wclk(H/2);
        acked = !sda_line; wclk(H/2);
        tb_scl = 1'b0;     wclk(H/2);
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] d);
        tb_sda_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wclk(H/2);
            tb_scl = 1'b1; wclk(H/2);
            d = {d[6:0], sda_line}; wclk(H/2);
            tb_scl = 1'b0;
        end
        wclk(H/2);
        send_bit(master_ack ? 1'b0 : 1'b1);
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {4'b1101, strap, rw};
    endfunction

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        send_byte(dev(1'b0), a); check("R1 address ack", a, 1);
        send_byte(p, a);         check("R6 pointer ack", a, 1);
        mptr = p;
    endtask

    task automatic write_data(input logic [7:0] d);
        logic a;
        settled = 1'b0;
        send_byte(d, a); check("R2 data ack", a, 1);
        if (mptr < 8 && mptr != 0 && mptr != 5) mdl[mptr] = d;
        mptr = (mptr + 1) & 255;
        settled = 1'b1;
    endtask

    task automatic begin_read(input logic [7:0] p);
        logic a;
        set_ptr(p);
        bus_start();
        send_byte(dev(1'b1), a); check("R3 read address ack", a, 1);
    endtask

    task automatic read_check(input bit mack, input string req);
        logic [7:0] d;
        recv_byte(mack, d);
        check(req, d, exp_reg(mptr));
        mptr = (mptr + 1) & 255;
    endtask

    task automatic set_pins(input logic [2:0] s, input logic [7:0] st);
        settled = 1'b0; strap = s; status = st; wclk(1); settled = 1'b1;
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        for (int k = 0; k < 8; k++) mdl[k] = 8'h00;
        wclk(5);
        check("R10 sda released in reset", sda_line, 1);
        rst_n = 1'b1; wclk(2);
        check("R10 reset image", regs, exp_image());
        settled = 1'b1;

        // R2: single write
        set_ptr(8'h01); write_data(8'hA5); bus_stop();
        check("R2 reg1 written", regs[15:8], 8'hA5);

        // R7 and R5: burst over registers 3..6, register 5 untouched
        set_ptr(8'h03);
        write_data(8'h11); write_data(8'h22); write_data(8'h33); write_data(8'h44);
        bus_stop();
        check("R7 reg6 via increment", regs[55:48], 8'h44);
        check("R5 status kept", regs[47:40], status);

        // R5 register 0 protected; R6 write above 7 ignored
        set_ptr(8'h00); write_data(8'hFF); bus_stop();
        set_ptr(8'h07); write_data(8'h77); write_data(8'h99); bus_stop();
        check("R6 image after high write", regs, exp_image());

        // R3, R4, R7, R6: read burst 0..8
        begin_read(8'h00);
        read_check(1, "R4 id register");
        for (int r = 1; r < 8; r++) read_check(1, "R7 read burst R3");
        read_check(0, "R6 read above 7");
        // R8: target released after NACK
        recv_byte(0, d);
        check("R8 released after nack", d, 8'hFF);
        bus_stop();

        // R5: status window follows the bus
        set_pins(3'b101, 8'hC3);
        begin_read(8'h05); read_check(0, "R5 status read"); bus_stop();

        // R1: mismatching address ignored until STOP
        bus_start();
        send_byte(8'hD4, a); check("R1 mismatch nack", a, 0);
        send_byte(8'h00, a); check("R1 stays off bus", a, 0);
        bus_stop();

        // R1, R4: new strap value moves the address
        set_pins(3'b010, 8'hC3);
        set_ptr(8'h02); write_data(8'h5C); bus_stop();
        begin_read(8'h00); read_check(1, "R4 id follows strap"); read_check(0, "R1 new address"); bus_stop();

        // R9: STOP in the middle of a data byte
        set_ptr(8'h02);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        check("R9 partial byte dropped", regs[23:16], 8'h5C);
        check("R9 sda released", sda_line, 1);
        set_ptr(8'h02); write_data(8'hE1); bus_stop();
        check("R9 recovers", regs[23:16], 8'hE1);

        // R10: reset clears writable registers
        settled = 1'b0; rst_n = 1'b0; wclk(4);
        for (int k = 0; k < 8; k++) mdl[k] = 8'h00;
        check("R10 sda in reset", sda_line, 1);
        rst_n = 1'b1; wclk(2);
        check("R10 cleared", regs, exp_image());
        settled = 1'b1; wclk(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule